// File: doc/BRIEF.md
# Vector Sum Reducer with Halving Fold

This block turns a stream of vector chunks into one scalar total. It keeps one 32-bit partial sum per lane, so no long carry chain runs through a single accumulator. Each accepted chunk adds lane by lane into those partial sums. The chunk that carries the end marker ends the gather phase. The block then folds the partial sums: on each cycle the upper half of the active lanes adds into the lower half, and the active length halves. When one lane remains, its value is the result.

Chunks enter on a valid/ready handshake. A chunk is taken at a rising clock edge where `in_valid` and `in_ready` are both high. The block drops `in_ready` for the whole fold phase, so the source must hold or withdraw its chunk until `in_ready` returns. The result leaves as a one-cycle `res_valid` pulse with `res_data`. There is no back-pressure on the result side. The active vector length is a configuration input that the block samples with the first chunk of each reduction.

Top module: `vec_sum_reducer`

## Requirements
- R1: After reset, `res_valid` is low and `in_ready` is high.
- R2: The active length VL is taken from `cfg_len` on the first chunk of each reduction. It must be a power of two from 1 to MAX_LANES. Any `cfg_len` value presented with later chunks of the same reduction has no effect.
- R3: Lane i is carried in `in_data` bits [32*i+31 : 32*i]. Lanes with index VL or above do not contribute to the result.
- R4: The result is the sum of lanes 0 to VL-1 over every chunk of the reduction, taken as 32-bit two's-complement and wrapped modulo 2^32.
- R5: After the edge that accepts a chunk marked last, `in_ready` stays low for exactly log2(VL) cycles. `res_valid` rises log2(VL) edges after that accepting edge, or on the very next cycle when VL is 1.
- R6: A chunk offered while `in_ready` is low is refused and has no effect on any result.
- R7: `res_valid` is high for one cycle per reduction, and `res_data` is valid in that cycle. `in_ready` is high during that cycle.
- R8: The partial sums start from zero for each new reduction. A reduction whose first chunk is also its last still gives the right result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Chunk offered |
| in_ready | output | 1 | Chunk can be accepted; low during the fold phase |
| in_data | input | MAX_LANES*DATA_W | Chunk elements; lane i at bits [DATA_W*i +: DATA_W] |
| in_last | input | 1 | Marks the final chunk of a reduction |
| cfg_len | input | $clog2(MAX_LANES)+1 | Active length VL, a power of two, sampled on the first chunk |
| res_data | output | DATA_W | Reduced sum, valid while res_valid is high |
| res_valid | output | 1 | One-cycle result strobe |

## Verification
The bench builds the block with its defaults, MAX_LANES=16 and DATA_W=32. With these values every legal length from 1 to 16 can be reached, and so can every fold depth from zero to four steps. Random data sits in the lanes above VL, and `cfg_len` changes on later chunks, so both R2 and R3 are exercised. Chunks offered during the fold test refusal. Saturated and all-ones operands force wraparound.

// File: rtl/vsr_pkg.sv
package vsr_pkg;
  typedef enum logic {
    ST_GATHER = 1'b0,
    ST_FOLD   = 1'b1
  } vsr_state_e;
endpackage

// File: rtl/vsr_ctrl.sv
module vsr_ctrl
  import vsr_pkg::*;
#(
  parameter int MAX_LANES = 16,
  parameter int LEN_W     = $clog2(MAX_LANES) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic [LEN_W-1:0] cfg_len,
  output logic             in_ready,
  output logic             load,
  output logic             first,
  output logic [LEN_W-1:0] len_eff,
  output logic             fold_en,
  output logic [LEN_W-1:0] half,
  output logic             res_valid
);
  vsr_state_e       state_q;
  logic [LEN_W-1:0] act_q;
  logic [LEN_W-1:0] len_q;
  logic             fresh_q;
  logic             res_q;

  assign in_ready  = (state_q == ST_GATHER);
  assign load      = in_valid && in_ready;
  assign first     = fresh_q;
  assign len_eff   = fresh_q ? cfg_len : len_q;
  assign fold_en   = (state_q == ST_FOLD);
  assign half      = act_q >> 1;
  assign res_valid = res_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_GATHER;
      act_q   <= LEN_W'(1);
      len_q   <= LEN_W'(1);
      fresh_q <= 1'b1;
      res_q   <= 1'b0;
    end else begin
      res_q <= 1'b0;
      if (load) begin
        fresh_q <= in_last;
        len_q   <= len_eff;
        if (in_last) begin
          if (len_eff == LEN_W'(1)) begin
            res_q <= 1'b1;
          end else begin
            state_q <= ST_FOLD;
            act_q   <= len_eff;
          end
        end
      end else if (fold_en) begin
        act_q <= half;
        if (act_q == LEN_W'(2)) begin
          state_q <= ST_GATHER;
          res_q   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vsr_lane.sv
module vsr_lane #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              first,
  input  logic              lane_en,
  input  logic [DATA_W-1:0] in_elem,
  input  logic              fold_add,
  input  logic [DATA_W-1:0] partner,
  output logic [DATA_W-1:0] acc
);
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] base;

  assign base = first ? '0 : acc_q;
  assign acc  = acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (load) begin
      acc_q <= lane_en ? (base + in_elem) : '0;
    end else if (fold_add) begin
      acc_q <= acc_q + partner;
    end
  end
endmodule

// File: rtl/vec_sum_reducer.sv
module vec_sum_reducer #(
  parameter int MAX_LANES = 16,
  parameter int DATA_W    = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [MAX_LANES*DATA_W-1:0]   in_data,
  input  logic                          in_last,
  input  logic [$clog2(MAX_LANES):0]    cfg_len,
  output logic [DATA_W-1:0]             res_data,
  output logic                          res_valid
);
  localparam int LEN_W = $clog2(MAX_LANES) + 1;
  localparam int LOG_W = $clog2(MAX_LANES);

  logic             load;
  logic             first;
  logic [LEN_W-1:0] len_eff;
  logic             fold_en;
  logic [LEN_W-1:0] half;

  logic [DATA_W-1:0] acc     [MAX_LANES];
  logic [DATA_W-1:0] partner [MAX_LANES];

  vsr_ctrl #(
    .MAX_LANES(MAX_LANES),
    .LEN_W    (LEN_W)
  ) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_last  (in_last),
    .cfg_len  (cfg_len),
    .in_ready (in_ready),
    .load     (load),
    .first    (first),
    .len_eff  (len_eff),
    .fold_en  (fold_en),
    .half     (half),
    .res_valid(res_valid)
  );

  for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane
    logic lane_en;
    logic fold_add;

    assign lane_en  = (LEN_W'(g) < len_eff);
    assign fold_add = fold_en && (LEN_W'(g) < half);

    // Partner is the lane one half-length above; half is a power of two.
    always_comb begin
      partner[g] = '0;
      for (int s = 0; s < LOG_W; s++) begin
        if ((half == LEN_W'(1 << s)) && ((g + (1 << s)) < MAX_LANES)) begin
          partner[g] = acc[(g + (1 << s)) % MAX_LANES];
        end
      end
    end

    vsr_lane #(
      .DATA_W(DATA_W)
    ) lane_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .first   (first),
      .lane_en (lane_en),
      .in_elem (in_data[g*DATA_W +: DATA_W]),
      .fold_add(fold_add),
      .partner (partner[g]),
      .acc     (acc[g])
    );
  end

  assign res_data = acc[0];
endmodule

// File: rtl/vec_sum_reducer_chk.sv
module vec_sum_reducer_chk #(
  parameter int MAX_LANES = 16,
  parameter int DATA_W    = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        in_valid,
  input logic                        in_ready,
  input logic                        in_last,
  input logic [$clog2(MAX_LANES):0]  cfg_len,
  input logic                        res_valid
);
  localparam int LOG_W = $clog2(MAX_LANES);
  localparam int CNT_W = LOG_W + 2;

  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)         busy_cnt <= '0;
    else if (!in_ready) busy_cnt <= busy_cnt + 1'b1;
    else                busy_cnt <= '0;
  end

  // R5: the fold phase never outlasts log2(MAX_LANES) cycles
  a_r5_fold_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= CNT_W'(LOG_W));

  // R5: ready only drops after a last chunk was offered and taken
  a_r5_fold_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(in_valid && in_last));

  // R7: no result strobe while chunks are refused
  a_r7_no_result_in_fold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> !res_valid);

  // R7: ready is back by the time the result appears
  a_r7_ready_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> in_ready);

  // R7: a result comes from a last-chunk accept or the end of a fold
  a_r7_result_source: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($past(in_valid && in_ready && in_last) || $past(!in_ready)));

  // R2: an accepted chunk presents a legal power-of-two length
  a_r2_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> ($onehot(cfg_len) && (int'(cfg_len) <= MAX_LANES)));
endmodule

bind vec_sum_reducer vec_sum_reducer_chk #(
  .MAX_LANES(MAX_LANES),
  .DATA_W   (DATA_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_last  (in_last),
  .cfg_len  (cfg_len),
  .res_valid(res_valid)
);

// File: tb/vec_sum_reducer_tb_top.sv
`timescale 1ns/1ps
module vec_sum_reducer_tb_top;
  localparam int LANES = 16;
  localparam int DW    = 32;
  localparam int LW    = $clog2(LANES) + 1;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                in_valid = 1'b0;
  logic                in_ready;
  logic [LANES*DW-1:0] in_data = '0;
  logic                in_last = 1'b0;
  logic [LW-1:0]       cfg_len = LW'(1);
  logic [DW-1:0]       res_data;
  logic                res_valid;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  vec_sum_reducer #(.MAX_LANES(LANES), .DATA_W(DW)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .in_last  (in_last),
    .cfg_len  (cfg_len),
    .res_data (res_data),
    .res_valid(res_valid)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] elem(input int mode);
    case (mode)
      1:       return 32'h7FFF_FFFF;
      2:       return 32'hFFFF_FFFF;
      default: return $urandom;
    endcase
  endfunction

  // One reduction: VL = 2**vl_log, nchunks chunks, optional refused junk during fold.
  task automatic reduce(input int vl_log, input int nchunks, input bit junk, input int mode);
    int            vl;
    int            cyc;
    logic [DW-1:0] exp;
    vl  = 1 << vl_log;
    exp = '0;
    for (int c = 0; c < nchunks; c++) begin
      int gap;
      gap = $urandom_range(0, 2);
      repeat (gap) begin
        in_valid = 1'b0;
        in_data  = {LANES{$urandom}};
        @(negedge clk);
      end
      for (int l = 0; l < LANES; l++) begin
        logic [DW-1:0] w;
        w = (l < vl) ? elem(mode) : $urandom;  // R3: upper lanes carry junk
        in_data[l*DW +: DW] = w;
        if (l < vl) exp = exp + w;             // R4: wrapping sum
      end
      in_valid = 1'b1;
      in_last  = (c == nchunks - 1);
      // R2: later chunks present some other legal length that must be ignored
      cfg_len  = (c == 0) ? LW'(vl) : LW'(1 << $urandom_range(0, 4));
      chk(in_ready == 1'b1, "R7 ready in gather", DW'(in_ready), 1);
      @(posedge clk);
      @(negedge clk);
    end
    cyc = 0;
    while (!res_valid && cyc < 40) begin
      chk(in_ready == 1'b0, "R5 ready low in fold", DW'(in_ready), 0);
      in_valid = junk;                         // R6: refused chunk
      in_last  = $urandom_range(0, 1);
      in_data  = {LANES{$urandom}};
      cfg_len  = LW'(1 << $urandom_range(0, 4));
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    chk(res_valid == 1'b1, "R7 result strobe", DW'(res_valid), 1);
    chk(cyc == vl_log, "R5 fold length", DW'(cyc), DW'(vl_log));
    chk(res_data == exp, (junk ? "R6 R4 sum with refused chunks" : "R4 sum"), res_data, exp);
    chk(in_ready == 1'b1, "R7 ready with result", DW'(in_ready), 1);
    @(posedge clk);
    @(negedge clk);
    chk(res_valid == 1'b0, "R7 single pulse", DW'(res_valid), 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(res_valid == 1'b0, "R1 reset res_valid", DW'(res_valid), 0);
    chk(in_ready == 1'b1, "R1 reset in_ready", DW'(in_ready), 1);

    // R8: single-chunk reductions at every length
    for (int k = 0; k <= 4; k++) reduce(k, 1, 1'b0, 0);
    // R4: wraparound with saturated and all-ones operands
    reduce(4, 3, 1'b0, 1);
    reduce(3, 5, 1'b1, 2);
    reduce(0, 4, 1'b1, 1);
    // R8: a long run, then a short one, so stale partials would show
    reduce(4, 6, 1'b0, 0);
    reduce(1, 1, 1'b1, 0);
    // R2 R3 R6: random mix
    for (int n = 0; n < 60; n++)
      reduce($urandom_range(0, 4), $urandom_range(1, 6), $urandom_range(0, 1), 0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule